// File: doc/BRIEF.md
# Counted Loop Branch Controller

This block closes counted, modulo-scheduled loops. It holds three pieces of loop state: a trip counter, a drain counter and a rotation base. Each time a loop-closing branch issues, the block works out the loop phase from the two counters. The phases are kernel (trip counter non-zero), drain (trip counter zero, drain counter above one), last (drain counter exactly one) and done (both zero). In each phase it steps the counters and decides whether the rotating registers advance. It also produces the bit that goes into the topmost rotating stage predicate, and whether the branch is taken.

Two branch flavours share the state and have opposite taken senses. The continue flavour branches back while the loop still has work to do. The exit flavour falls through in those cases and branches once the loop is over. Before the loop starts, software loads the trip counter with the iteration count minus one and the drain counter with the number of pipeline stages. It can also load the rotation base or clear it.

Top module: `loop_branch_ctrl`

## Requirements
- R1: In the kernel phase (trip counter non-zero) a branch decrements the trip counter, keeps the drain counter, asserts `rotate_o`, sets `top_pred_o` to 1 and decrements the rotation base.
- R2: In the drain phase (trip counter zero, drain counter greater than 1) a branch keeps the trip counter, decrements the drain counter, asserts `rotate_o`, sets `top_pred_o` to 0 and decrements the rotation base.
- R3: In the last phase (trip counter zero, drain counter equal to 1) a branch sets the drain counter to 0, asserts `rotate_o`, sets `top_pred_o` to 0 and decrements the rotation base.
- R4: In the done phase (both counters zero) a branch leaves all three state values unchanged, keeps `rotate_o` at 0 and sets `top_pred_o` to 0.
- R5: With `br_kind`=0 (continue flavour) the branch is taken in the kernel and drain phases and not taken in the last and done phases. With `br_kind`=1 (exit flavour) the taken sense is inverted in every phase.
- R6: A write with `wr_sel`=0 loads the trip counter, 1 loads the drain counter, 2 loads the rotation base from the low bits of `wr_data`, and 3 clears the rotation base. The new value shows on the state outputs one cycle later.
- R7: The rotation base wraps modulo ROT_SIZE (default 96): decrementing it from 0 gives ROT_SIZE-1, and it never holds a value of ROT_SIZE or above.
- R8: `taken_o`, `rotate_o` and `top_pred_o` are registered. They reflect a branch one cycle after its strobe and are 0 in any cycle that follows a cycle without an accepted branch.
- R9: When `wr_en` and `br_valid` are high in the same cycle, the write is performed and the branch is dropped: no rotate, not taken, and no counter stepping.
- R10: After reset the trip counter, drain counter, rotation base and all branch outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Loop-closing branch strobe |
| br_kind | input | 1 | 0 = continue flavour, 1 = exit flavour |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | 0 trip counter, 1 drain counter, 2 rotation base, 3 clear rotation base |
| wr_data | input | CNT_W | Write data |
| lc_o | output | CNT_W | Current trip counter |
| ec_o | output | CNT_W | Current drain counter |
| rrb_o | output | RRB_W | Current rotation base |
| taken_o | output | 1 | Branch taken, one cycle after the strobe |
| rotate_o | output | 1 | Register rotation pulse, one cycle after the strobe |
| top_pred_o | output | 1 | Value for the top rotating predicate |

## Verification
The assertions assume that any value software writes into the rotation base is already below ROT_SIZE, because the write path stores the low bits and does not reduce them. The stimulus only loads rotation-base values in range, reaching the upper end through wrap-around decrements instead. The assertions also assume that `br_kind` is a known value whenever `br_valid` is high. The bench always drives both together, and drives every input at the falling edge.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic {
        BR_CONT = 1'b0,
        BR_EXIT = 1'b1
    } br_kind_e;

    typedef enum logic [1:0] {
        SEL_TRIP  = 2'd0,
        SEL_DRAIN = 2'd1,
        SEL_BASE  = 2'd2,
        SEL_CLEAR = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        PH_KERNEL = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_LAST   = 2'd2,
        PH_DONE   = 2'd3
    } loop_phase_e;

endpackage

// File: rtl/lbc_decide.sv
module lbc_decide
    import lbc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] lc_i,
    input  logic [CNT_W-1:0] ec_i,
    input  logic             kind_i,
    output logic [CNT_W-1:0] lc_next_o,
    output logic [CNT_W-1:0] ec_next_o,
    output logic             rotate_o,
    output logic             pred_o,
    output logic             taken_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    loop_phase_e phase;
    logic        cont_taken;

    always_comb begin
        if (lc_i != '0)       phase = PH_KERNEL;
        else if (ec_i > ONE)  phase = PH_DRAIN;
        else if (ec_i == ONE) phase = PH_LAST;
        else                  phase = PH_DONE;
    end

    always_comb begin
        lc_next_o  = lc_i;
        ec_next_o  = ec_i;
        rotate_o   = 1'b0;
        pred_o     = 1'b0;
        cont_taken = 1'b0;
        unique case (phase)
            PH_KERNEL: begin
                lc_next_o  = lc_i - ONE;
                rotate_o   = 1'b1;
                pred_o     = 1'b1;
                cont_taken = 1'b1;
            end
            PH_DRAIN: begin
                ec_next_o  = ec_i - ONE;
                rotate_o   = 1'b1;
                cont_taken = 1'b1;
            end
            PH_LAST: begin
                ec_next_o  = ec_i - ONE;
                rotate_o   = 1'b1;
            end
            PH_DONE: begin
            end
            default: begin
            end
        endcase
        taken_o = (br_kind_e'(kind_i) == BR_EXIT) ? !cont_taken : cont_taken;
    end

endmodule

// File: rtl/lbc_rrb_dec.sv
module lbc_rrb_dec #(
    parameter int RRB_W    = 7,
    parameter int ROT_SIZE = 96
) (
    input  logic [RRB_W-1:0] rrb_i,
    output logic [RRB_W-1:0] rrb_o
);

    localparam logic [RRB_W-1:0] TOP = RRB_W'(ROT_SIZE - 1);

    always_comb begin
        if (rrb_i == '0) rrb_o = TOP;
        else             rrb_o = rrb_i - RRB_W'(1);
    end

endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
    import lbc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int RRB_W    = 7,
    parameter int ROT_SIZE = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_valid,
    input  logic             br_kind,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] lc_o,
    output logic [CNT_W-1:0] ec_o,
    output logic [RRB_W-1:0] rrb_o,
    output logic             taken_o,
    output logic             rotate_o,
    output logic             top_pred_o
);

    localparam logic [RRB_W-1:0] BASE_LIMIT = RRB_W'(ROT_SIZE);

    typedef struct packed {
        logic [CNT_W-1:0] lc;
        logic [CNT_W-1:0] ec;
        logic [RRB_W-1:0] rrb;
        logic             taken;
        logic             rotate;
        logic             pred;
    } ctrl_state_t;

    ctrl_state_t state_d, state_q;

    logic [CNT_W-1:0] lc_nx, ec_nx;
    logic             rot_nx, pred_nx, taken_nx;
    logic [RRB_W-1:0] rrb_dec;

    lbc_decide #(.CNT_W(CNT_W)) u_decide (
        .lc_i      (state_q.lc),
        .ec_i      (state_q.ec),
        .kind_i    (br_kind),
        .lc_next_o (lc_nx),
        .ec_next_o (ec_nx),
        .rotate_o  (rot_nx),
        .pred_o    (pred_nx),
        .taken_o   (taken_nx)
    );

    lbc_rrb_dec #(.RRB_W(RRB_W), .ROT_SIZE(ROT_SIZE)) u_rrb_dec (
        .rrb_i (state_q.rrb),
        .rrb_o (rrb_dec)
    );

    always_comb begin
        state_d        = state_q;
        state_d.taken  = 1'b0;
        state_d.rotate = 1'b0;
        state_d.pred   = 1'b0;
        if (wr_en) begin
            unique case (wr_sel_e'(wr_sel))
                SEL_TRIP:  state_d.lc  = wr_data;
                SEL_DRAIN: state_d.ec  = wr_data;
                SEL_BASE:  state_d.rrb = wr_data[RRB_W-1:0];
                SEL_CLEAR: state_d.rrb = '0;
                default:   state_d.rrb = state_q.rrb;
            endcase
        end else if (br_valid) begin
            state_d.lc     = lc_nx;
            state_d.ec     = ec_nx;
            state_d.rrb    = rot_nx ? rrb_dec : state_q.rrb;
            state_d.taken  = taken_nx;
            state_d.rotate = rot_nx;
            state_d.pred   = pred_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lc_o       = state_q.lc;
    assign ec_o       = state_q.ec;
    assign rrb_o      = state_q.rrb;
    assign taken_o    = state_q.taken;
    assign rotate_o   = state_q.rotate;
    assign top_pred_o = state_q.pred;

    assert_kernel_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !wr_en && lc_o != '0) |=>
            (lc_o == $past(lc_o) - CNT_W'(1)) && (ec_o == $past(ec_o)) && rotate_o && top_pred_o);

    assert_drain_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !wr_en && lc_o == '0 && ec_o > CNT_W'(1)) |=>
            (ec_o == $past(ec_o) - CNT_W'(1)) && (lc_o == '0) && rotate_o && !top_pred_o);

    assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !wr_en && lc_o == '0 && ec_o == '0) |=>
            $stable(lc_o) && $stable(ec_o) && $stable(rrb_o) && !rotate_o && !top_pred_o);

    assert_base_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rrb_o < BASE_LIMIT);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !taken_o && !rotate_o && !top_pred_o);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && br_valid) |=> !rotate_o && !taken_o);

endmodule

// File: tb/test_loop_branch_ctrl.sv
module test_loop_branch_ctrl;

    localparam int CNT_W    = 16;
    localparam int RRB_W    = 7;
    localparam int ROT_SIZE = 96;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             br_valid = 1'b0;
    logic             br_kind = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] lc_o, ec_o;
    logic [RRB_W-1:0] rrb_o;
    logic             taken_o, rotate_o, top_pred_o;

    int checks = 0;
    int failures = 0;
    int m_lc = 0, m_ec = 0, m_rrb = 0;

    always #10 clk = ~clk;

    loop_branch_ctrl #(.CNT_W(CNT_W), .RRB_W(RRB_W), .ROT_SIZE(ROT_SIZE)) i_loop_branch_ctrl (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lc_o(lc_o), .ec_o(ec_o), .rrb_o(rrb_o),
        .taken_o(taken_o), .rotate_o(rotate_o), .top_pred_o(top_pred_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, "trip", int'(lc_o), m_lc);
        chk(req, "drain", int'(ec_o), m_ec);
        chk(req, "base", int'(rrb_o), m_rrb);
    endtask

    task automatic sw_write(input int sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = val[CNT_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: m_lc = val;
            1: m_ec = val;
            2: m_rrb = val;
            default: m_rrb = 0;
        endcase
        chk("R6", "write visible", sel < 2 ? (sel == 0 ? int'(lc_o) : int'(ec_o)) : int'(rrb_o),
            sel == 0 ? m_lc : (sel == 1 ? m_ec : m_rrb));
    endtask

    // Expected result from the phase table of R1..R5
    task automatic branch(input int kind, input string req);
        int e_take, e_rot, e_pred, cont;
        if (m_lc != 0)      begin e_rot = 1; e_pred = 1; cont = 1; m_lc--; end
        else if (m_ec > 1)  begin e_rot = 1; e_pred = 0; cont = 1; m_ec--; end
        else if (m_ec == 1) begin e_rot = 1; e_pred = 0; cont = 0; m_ec--; end
        else                begin e_rot = 0; e_pred = 0; cont = 0; end
        if (e_rot == 1) m_rrb = (m_rrb == 0) ? ROT_SIZE - 1 : m_rrb - 1;
        e_take = (kind == 1) ? 1 - cont : cont;
        @(negedge clk);
        br_valid = 1'b1; br_kind = kind[0];
        @(negedge clk);
        br_valid = 1'b0;
        chk(req, "rotate", int'(rotate_o), e_rot);
        chk(req, "top_pred", int'(top_pred_o), e_pred);
        chk("R5", "taken", int'(taken_o), e_take);
        chk_state(req);
    endtask

    task automatic t_reset();
        chk("R10", "trip", int'(lc_o), 0);
        chk("R10", "drain", int'(ec_o), 0);
        chk("R10", "base", int'(rrb_o), 0);
        chk("R10", "outs", int'({taken_o, rotate_o, top_pred_o}), 0);
    endtask

    task automatic t_cont_loop();
        sw_write(0, 2);
        sw_write(1, 3);
        sw_write(3, 0);
        branch(0, "R1");
        branch(0, "R1");
        branch(0, "R2");
        branch(0, "R2");
        branch(0, "R3");
        branch(0, "R4");
        chk("R7", "wrapped base", int'(rrb_o), ROT_SIZE - 5);
    endtask

    task automatic t_exit_loop();
        sw_write(2, 10);
        sw_write(0, 1);
        sw_write(1, 2);
        branch(1, "R1");
        branch(1, "R2");
        branch(1, "R3");
        branch(1, "R4");
        branch(1, "R4");
    endtask

    task automatic t_wrap();
        sw_write(3, 0);
        sw_write(0, 3);
        branch(0, "R7");
        chk("R7", "wrap from zero", int'(rrb_o), ROT_SIZE - 1);
        branch(1, "R7");
    endtask

    task automatic t_idle();
        sw_write(0, 4);
        branch(0, "R8");
        @(negedge clk);
        chk("R8", "rotate idle", int'(rotate_o), 0);
        chk("R8", "taken idle", int'(taken_o), 0);
        chk("R8", "pred idle", int'(top_pred_o), 0);
    endtask

    task automatic t_priority();
        sw_write(0, 5);
        sw_write(2, 20);
        @(negedge clk);
        br_valid = 1'b1; br_kind = 1'b0;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = CNT_W'(7);
        @(negedge clk);
        br_valid = 1'b0; wr_en = 1'b0;
        m_ec = 7;
        chk("R9", "rotate dropped", int'(rotate_o), 0);
        chk("R9", "taken dropped", int'(taken_o), 0);
        chk_state("R9");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cont_loop();
        t_exit_loop();
        t_wrap();
        t_idle();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule